// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table from memory and then checks the request against the permission bits in the entries it has read. A request carries the virtual address, a write flag and a user-mode flag. The walker also samples the page-directory base input when it accepts the request.

The walk always starts with one fetch from the directory. If that directory entry is present, a second fetch reads the leaf entry. The walker then returns either a physical address or a fault code together with the virtual address that caused it.

The walker handles one request at a time. Memory reads go through a single read port: the walker holds a request and an address until the memory raises ready, and the data arrives in that same cycle. The memory may take any number of cycles to answer.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, `req_ready` is 1, and `busy`, `resp_valid` and `mem_rd_valid` are all 0.
- R2: The first fetch of a walk reads address `base + 4*va[31:22]`. Here `base` is the value `dir_base` had in the cycle the request was accepted; later changes to `dir_base` do not affect the walk.
- R3: The second fetch reads address `{pde[31:12], 12'h000} + 4*va[21:12]`, where `pde` is the directory entry returned by the first fetch.
- R4: A permitted access responds with `resp_fault` = 0, `resp_paddr` = `{pte[31:12], va[11:0]}` and `resp_fault_vaddr` = 0.
- R5: A directory entry with bit 0 (present) clear responds with fault code 1, and no second fetch is made.
- R6: A leaf entry with bit 0 clear responds with fault code 2. This code has priority over codes 3 and 4.
- R7: A user-mode request needs bit 2 (user allowed) set in both entries, or it faults with code 3. Code 3 has priority over code 4. For supervisor requests, bit 2 has no effect.
- R8: A write request needs bit 1 (writable) set in both entries, or it faults with code 4. For reads, bit 1 has no effect.
- R9: On any fault, `resp_paddr` is 0 and `resp_fault_vaddr` equals the request's virtual address.
- R10: `resp_valid` is high for exactly one cycle: the cycle after the final memory handshake of the walk. `mem_rd_valid` is low during that cycle. While `mem_rd_valid` waits for `mem_rd_ready`, `mem_rd_addr` holds steady.
- R11: From the cycle after acceptance up to and including the response cycle, `busy` is 1 and `req_ready` is 0. A `req_valid` asserted in that window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request taken when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| dir_base | input | 32 | Byte address of the page directory |
| busy | output | 1 | A walk is in progress |
| mem_rd_valid | output | 1 | Table entry fetch requested |
| mem_rd_addr | output | 32 | Byte address of the entry |
| mem_rd_ready | input | 1 | Memory completes the fetch this cycle |
| mem_rd_data | input | 32 | Entry word, valid with mem_rd_ready |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| resp_fault | output | 3 | 0 none, 1 dir absent, 2 leaf absent, 3 privilege, 4 write |
| resp_fault_vaddr | output | 32 | Faulting virtual address, 0 when no fault |

## Verification
Each fetch address is due in the cycle that the memory model completes the handshake. The model checks the address against the value it computes itself from the virtual address and the base it recorded at acceptance. The result of a walk is due one cycle after the final handshake. That is the second handshake, or the first one if the directory entry is absent.

The bench notes the cycle of each final handshake. On every falling edge it compares `resp_valid` with "this is that cycle plus one", so a late, early or extra response is caught. Memory latency ranges from zero to four wait cycles, so the timing checks cover both back-to-back fetches and stalled ones.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  localparam int PT_AW     = 32;  // virtual and physical address width
  localparam int PT_OFS    = 12;  // page offset bits
  localparam int PT_IDX    = 10;  // index bits per table level
  localparam int PT_ENT_SH = 2;   // log2 of entry size in bytes

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_USER     = 2;

  typedef logic [PT_AW-1:0] addr_t;
  typedef logic [PT_AW-1:0] entry_t;

  typedef enum logic [2:0] {
    FLT_NONE        = 3'd0,
    FLT_DIR_ABSENT  = 3'd1,
    FLT_LEAF_ABSENT = 3'd2,
    FLT_PRIV        = 3'd3,
    FLT_WRITE       = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    WS_IDLE,
    WS_DIR,
    WS_LEAF,
    WS_RESP
  } walk_state_e;

  // Directory slot: base plus the top index scaled by the entry size.
  function automatic addr_t dir_slot_addr(addr_t base, addr_t va);
    addr_t idx;
    idx = addr_t'(va[PT_AW-1 -: PT_IDX]);
    return base + (idx << PT_ENT_SH);
  endfunction

  // Leaf slot: frame of the directory entry plus the middle index scaled.
  function automatic addr_t leaf_slot_addr(entry_t pde, addr_t va);
    addr_t idx;
    idx = addr_t'(va[PT_OFS +: PT_IDX]);
    return {pde[PT_AW-1:PT_OFS], {PT_OFS{1'b0}}} + (idx << PT_ENT_SH);
  endfunction

  // Physical address: leaf frame joined with the untouched page offset.
  function automatic addr_t phys_of(entry_t pte, addr_t va);
    return {pte[PT_AW-1:PT_OFS], va[PT_OFS-1:0]};
  endfunction

endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_walker_pkg::*;
(
  input  logic [2:0] dir_flags,
  input  logic [2:0] leaf_flags,
  input  logic       is_write,
  input  logic       is_user,
  output fault_e     verdict
);

  logic leaf_present;
  logic user_ok;
  logic write_ok;

  always_comb begin
    leaf_present = leaf_flags[BIT_PRESENT];
    user_ok      = dir_flags[BIT_USER] & leaf_flags[BIT_USER];
    write_ok     = dir_flags[BIT_WRITABLE] & leaf_flags[BIT_WRITABLE];
    if (!leaf_present)             verdict = FLT_LEAF_ABSENT;
    else if (is_user && !user_ok)  verdict = FLT_PRIV;
    else if (is_write && !write_ok) verdict = FLT_WRITE;
    else                           verdict = FLT_NONE;
  end

endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_ready,
  input  logic dir_present,
  output logic req_ready,
  output logic busy,
  output logic mem_rd_valid,
  output logic sel_leaf,
  output logic resp_valid,
  output logic ev_accept,
  output logic ev_dir_done,
  output logic ev_leaf_done
);

  walk_state_e state_q, state_d;

  always_comb begin
    req_ready    = (state_q == WS_IDLE);
    busy         = (state_q != WS_IDLE);
    mem_rd_valid = (state_q == WS_DIR) || (state_q == WS_LEAF);
    sel_leaf     = (state_q == WS_LEAF);
    resp_valid   = (state_q == WS_RESP);
    ev_accept    = req_ready && req_valid;
    ev_dir_done  = (state_q == WS_DIR) && mem_rd_ready;
    ev_leaf_done = (state_q == WS_LEAF) && mem_rd_ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE: if (req_valid) state_d = WS_DIR;
      WS_DIR:  if (mem_rd_ready) state_d = dir_present ? WS_LEAF : WS_RESP;
      WS_LEAF: if (mem_rd_ready) state_d = WS_RESP;
      WS_RESP: state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PT_AW-1:0] req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PT_AW-1:0] dir_base,
  output logic             busy,
  output logic             mem_rd_valid,
  output logic [PT_AW-1:0] mem_rd_addr,
  input  logic             mem_rd_ready,
  input  logic [PT_AW-1:0] mem_rd_data,
  output logic             resp_valid,
  output logic [PT_AW-1:0] resp_paddr,
  output logic [2:0]       resp_fault,
  output logic [PT_AW-1:0] resp_fault_vaddr
);

  addr_t  va_q, base_q;
  entry_t pde_q;
  logic   wr_q, usr_q;
  logic   sel_leaf;
  fault_e res_fault_q;
  addr_t  res_pa_q, res_fva_q;
  fault_e leaf_verdict;

  // Named internal events, visible to the bound checker.
  logic ev_accept, ev_dir_done, ev_leaf_done, ev_dir_absent;

  pt_walk_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rd_ready (mem_rd_ready),
    .dir_present  (mem_rd_data[BIT_PRESENT]),
    .req_ready    (req_ready),
    .busy         (busy),
    .mem_rd_valid (mem_rd_valid),
    .sel_leaf     (sel_leaf),
    .resp_valid   (resp_valid),
    .ev_accept    (ev_accept),
    .ev_dir_done  (ev_dir_done),
    .ev_leaf_done (ev_leaf_done)
  );

  pt_perm_check u_perm (
    .dir_flags  (pde_q[2:0]),
    .leaf_flags (mem_rd_data[2:0]),
    .is_write   (wr_q),
    .is_user    (usr_q),
    .verdict    (leaf_verdict)
  );

  assign ev_dir_absent = ev_dir_done && !mem_rd_data[BIT_PRESENT];

  assign mem_rd_addr = sel_leaf ? leaf_slot_addr(pde_q, va_q)
                                : dir_slot_addr(base_q, va_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      pde_q  <= '0;
    end else begin
      if (ev_accept) begin
        va_q   <= req_vaddr;
        base_q <= dir_base;
        wr_q   <= req_write;
        usr_q  <= req_user;
      end
      if (ev_dir_done) pde_q <= mem_rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault_q <= FLT_NONE;
      res_pa_q    <= '0;
      res_fva_q   <= '0;
    end else if (ev_dir_absent) begin
      res_fault_q <= FLT_DIR_ABSENT;
      res_pa_q    <= '0;
      res_fva_q   <= va_q;
    end else if (ev_leaf_done) begin
      res_fault_q <= leaf_verdict;
      res_pa_q    <= (leaf_verdict == FLT_NONE) ? phys_of(mem_rd_data, va_q) : '0;
      res_fva_q   <= (leaf_verdict == FLT_NONE) ? '0 : va_q;
    end
  end

  assign resp_paddr       = res_pa_q;
  assign resp_fault       = res_fault_q;
  assign resp_fault_vaddr = res_fva_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [31:0] mem_rd_addr,
  input logic        resp_valid,
  input logic [31:0] resp_paddr,
  input logic [2:0]  resp_fault,
  input logic        ev_dir_absent
);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_valid && !resp_valid);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_resp_after_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(mem_rd_valid && mem_rd_ready));

  p_dir_absent_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_absent |=> resp_valid && resp_fault == 3'd1 && !mem_rd_valid);

  p_fault_zero_pa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault != 3'd0 |-> resp_paddr == 32'd0);

  p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_fault <= 3'd4);

endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_ready  (mem_rd_ready),
  .mem_rd_addr   (mem_rd_addr),
  .resp_valid    (resp_valid),
  .resp_paddr    (resp_paddr),
  .resp_fault    (resp_fault),
  .ev_dir_absent (ev_dir_absent)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_user, busy;
  logic [31:0] req_vaddr, dir_base;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr, mem_rd_data;
  logic        resp_valid;
  logic [31:0] resp_paddr, resp_fault_vaddr;
  logic [2:0]  resp_fault;

  pt_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .dir_base(dir_base), .busy(busy), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .resp_fault_vaddr(resp_fault_vaddr)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] pa;
    logic [2:0]  f;
    logic [31:0] fva;
  } exp_t;

  localparam logic [31:0] B1 = 32'h0010_0000;
  localparam logic [31:0] B2 = 32'h0050_0000;

  logic [31:0] mem [int unsigned];
  exp_t        exp_q[$];
  int          checks = 0, failures = 0;
  int          cyc = 0, resp_due = -1, mem_lat = 0;
  bit          started = 0;
  logic [31:0] cur_va, cur_base;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic exp_t model(input logic [31:0] base, input logic [31:0] va,
                                 input bit wr, input bit usr);
    exp_t e;
    logic [31:0] pde, pte;
    pde = rd(base + (va / 32'd4194304) * 4);
    if (pde % 2 == 0) begin
      e.f = 3'd1;
    end else begin
      pte = rd((pde & 32'hFFFF_F000) + ((va / 32'd4096) % 1024) * 4);
      if (pte % 2 == 0)                      e.f = 3'd2;
      else if (usr && !(pde[2] && pte[2]))   e.f = 3'd3;
      else if (wr && !(pde[1] && pte[1]))    e.f = 3'd4;
      else                                   e.f = 3'd0;
      if (e.f == 3'd0) e.pa = (pte & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
    end
    if (e.f != 3'd0) begin e.pa = 32'h0; e.fva = va; end
    else e.fva = 32'h0;
    return e;
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Memory responder with programmable wait cycles; checks fetch addresses.
  initial begin
    int fidx = 0;
    int wcnt = 0;
    logic [31:0] pde_seen = 32'h0;
    logic [31:0] want;
    mem_rd_ready = 1'b0;
    mem_rd_data  = 32'h0;
    forever begin
      @(negedge clk);
      mem_rd_ready = 1'b0;
      if (rst_n && mem_rd_valid) begin
        if (wcnt < mem_lat) wcnt++;
        else begin
          if (fidx == 0) begin
            want = cur_base + (cur_va / 32'd4194304) * 4;
            check(mem_rd_addr == want, "R2", "directory fetch address", mem_rd_addr, want);
          end else begin
            want = (pde_seen & 32'hFFFF_F000) + ((cur_va / 32'd4096) % 1024) * 4;
            check(mem_rd_addr == want, "R3", "leaf fetch address", mem_rd_addr, want);
          end
          mem_rd_data  = rd(mem_rd_addr);
          mem_rd_ready = 1'b1;
          wcnt = 0;
          if (fidx == 0 && mem_rd_data[0]) begin
            pde_seen = mem_rd_data;
            fidx = 1;
          end else begin
            fidx = 0;
            resp_due = cyc + 1;
          end
        end
      end
    end
  end

  // Cycle-by-cycle comparison of the response channel.
  bit   exp_rv;
  exp_t e_cur;
  always @(negedge clk) begin
    if (rst_n && started) begin
      exp_rv = (cyc == resp_due);
      check(resp_valid == exp_rv, "R10", "resp_valid timing", {31'h0, resp_valid}, {31'h0, exp_rv});
      if (exp_rv)
        check(!mem_rd_valid, "R10", "no fetch in response cycle", {31'h0, mem_rd_valid}, 32'h0);
      if (resp_valid && exp_q.size() > 0) begin
        e_cur = exp_q.pop_front();
        check(resp_fault == e_cur.f, tag_of(e_cur.f), "fault code", {29'h0, resp_fault}, {29'h0, e_cur.f});
        check(resp_paddr == e_cur.pa, (e_cur.f == 0) ? "R4" : "R9", "physical address", resp_paddr, e_cur.pa);
        check(resp_fault_vaddr == e_cur.fva, "R9", "fault vaddr", resp_fault_vaddr, e_cur.fva);
      end
    end
  end

  task automatic issue(input logic [31:0] va, input bit wr, input bit usr,
                       input bit noise, input bit swap_base);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_va   = va;
    cur_base = dir_base;
    exp_q.push_back(model(dir_base, va, wr, usr));
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy && !req_ready, "R11", "busy after accept", {30'h0, busy, req_ready}, 32'h2);
    if (swap_base) dir_base = B2;  // R2: must not affect walk in flight
    if (noise) begin  // R11: requests while busy are ignored
      req_valid = 1'b1; req_vaddr = va ^ 32'h0040_0000; req_write = ~wr; req_user = ~usr;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!busy && req_ready, "R11", "idle after response", {30'h0, busy, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = 32'h0; req_write = 1'b0;
    req_user = 1'b0; dir_base = B1; cur_va = 32'h0; cur_base = B1;
    // directory B1
    mem[B1 + 4]    = 32'h0020_0007;
    mem[B1 + 8]    = 32'h0020_1001;
    mem[B1 + 16]   = 32'h0020_2006;
    mem[B1 + 4092] = 32'h0020_3007;
    // leaf tables
    mem[32'h0020_0000] = 32'h1234_5007;
    mem[32'h0020_0004] = 32'h2222_2001;
    mem[32'h0020_000C] = 32'h3333_3005;
    mem[32'h0020_1014] = 32'h4444_4007;
    mem[32'h0020_3FFC] = 32'hABCD_E007;
    // second directory
    mem[B2 + 4]        = 32'h0020_4007;
    mem[32'h0020_4000] = 32'h5555_5007;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1", "req_ready in reset", {31'h0, req_ready}, 32'h1);
    check(busy == 1'b0, "R1", "busy in reset", {31'h0, busy}, 32'h0);
    check(resp_valid == 1'b0, "R1", "resp_valid in reset", {31'h0, resp_valid}, 32'h0);
    check(mem_rd_valid == 1'b0, "R1", "mem_rd_valid in reset", {31'h0, mem_rd_valid}, 32'h0);
    rst_n = 1'b1;
    started = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !mem_rd_valid, "R1", "idle after reset",
          {29'h0, req_ready, busy, mem_rd_valid}, 32'h4);

    mem_lat = 0;
    issue(32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 1'b0);  // R4 user read
    issue(32'h0040_0ABC, 1'b1, 1'b1, 1'b0, 1'b0);  // R4 user write
    mem_lat = 2;
    issue(32'h0040_1010, 1'b0, 1'b1, 1'b0, 1'b0);  // R7 user on supervisor page
    issue(32'h0040_1010, 1'b0, 1'b0, 1'b0, 1'b0);  // R7 supervisor ignores bit 2
    issue(32'h0040_1010, 1'b1, 1'b0, 1'b0, 1'b0);  // R8 write to read-only
    issue(32'h0040_1010, 1'b1, 1'b1, 1'b0, 1'b0);  // R7 over R8
    mem_lat = 1;
    issue(32'h0040_2000, 1'b0, 1'b0, 1'b0, 1'b0);  // R6
    issue(32'h0040_2000, 1'b1, 1'b1, 1'b0, 1'b0);  // R6 over R7/R8
    mem_lat = 3;
    issue(32'h0040_3FFC, 1'b0, 1'b1, 1'b0, 1'b0);  // R8 read ignores bit 1
    issue(32'h0040_3FFC, 1'b1, 1'b1, 1'b0, 1'b0);  // R8 user write read-only
    issue(32'h0080_5000, 1'b0, 1'b1, 1'b0, 1'b0);  // R7 directory-level bit 2
    issue(32'h0080_5000, 1'b1, 1'b0, 1'b0, 1'b0);  // R8 directory-level bit 1
    issue(32'h0080_5000, 1'b0, 1'b0, 1'b0, 1'b0);  // R4
    mem_lat = 0;
    issue(32'h00C0_0000, 1'b0, 1'b0, 1'b0, 1'b0);  // R5 empty directory slot
    issue(32'h0100_0123, 1'b1, 1'b1, 1'b0, 1'b0);  // R5 flags set but not present
    issue(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);  // R4 top corner
    issue(32'h00C0_0000, 1'b0, 1'b0, 1'b1, 1'b0);  // R11 noise, short walk
    mem_lat = 2;
    issue(32'h0040_0ABC, 1'b0, 1'b1, 1'b1, 1'b0);  // R11 noise, full walk
    mem_lat = 4;
    issue(32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 1'b1);  // R2 base change mid-walk
    issue(32'h0040_0ABC, 1'b0, 1'b1, 1'b0, 1'b0);  // R2 new base now used
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10", "all responses seen", exp_q.size(), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule